// File: doc/BRIEF.md
# Hot-Swap Deactivation Sequencer

This block is the state machine inside a board management controller that takes a plug-in board from its active state to its inactive state when the board is pulled out. Opening the board's ejector latch presses an active-low push-button. The sequencer then sends a deactivation request to the shelf manager and waits for a grant or a deny.

Once the request is granted, two shutdown paths are possible. If an OS with ACPI power management is loaded, the sequencer drives an active-low pulse on the chipset's power-button line. It then waits until both sleep-state indications are asserted, or until a long shutdown timer runs out. If no such OS is loaded, it removes payload power at once. Power-off drops payload enable and sets a sticky lock bit, and the board then rests in its inactive state until reset. A software deactivate command enters the sequence directly at the shutdown step, without any request to the shelf manager.

Pulse width and timeout are set in milliseconds and scaled by a clock-frequency parameter. The sleep inputs and the latch input pass through two-flop synchronizers.

Top module: `hs_deact_seq`

## Requirements
- R1: While reset is applied and after it is released, the outputs are mstate=4, deact_req=0, pwr_btn_n=1, payload_en=1 and locked=0.
- R2: In state 4, a high-to-low transition of latch_btn_n moves the block to state 5 with deact_req=1. A latch held low does not start a second request.
- R3: In state 5, shm_deny moves the block back to state 4 and clears deact_req, and deny wins when grant and deny are high together. shm_grant alone moves the block to state 6.
- R4: On entering state 6 with acpi_os_present=1, pwr_btn_n goes low in the same cycle as mstate becomes 6. It stays low for exactly PULSE_MS*CLK_HZ/1000 cycles.
- R5: On entering state 6 with acpi_os_present=0, there is no pulse. payload_en goes to 0 and locked goes to 1 in the same cycle that mstate becomes 6.
- R6: While waiting in state 6, power-off starts three clock edges after both sleep_s3_n and sleep_s5_n are driven low (two synchronizer stages and one state edge). This happens well before the timeout.
- R7: If both sleep inputs are not low together, payload_en drops exactly TIMEOUT_MS*CLK_HZ/1000 cycles after the block enters state 6. One sleep input alone does not end the wait.
- R8: Power-off clears payload_en and sets locked while mstate is still 6. mstate becomes 1 on the next edge, and mstate=1 implies locked=1 and payload_en=0.
- R9: sw_deact in state 4 or state 5 enters the state-6 shutdown step directly, with deact_req low. sw_deact takes priority over the latch, grant and deny.
- R10: State 1 is terminal: mstate, payload_en and locked keep their values and every input is ignored until reset.
- R11: mstate only takes the codes 1 (inactive), 4 (active), 5 (deactivation requested) and 6 (shutting down).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| latch_btn_n | input | 1 | Ejector-latch push-button, low when the latch is open |
| shm_grant | input | 1 | Shelf manager grants the deactivation request |
| shm_deny | input | 1 | Shelf manager denies the deactivation request |
| acpi_os_present | input | 1 | An ACPI-capable OS is loaded |
| sleep_s3_n | input | 1 | S3 sleep indication from the chipset, active low |
| sleep_s5_n | input | 1 | S5 sleep indication from the chipset, active low |
| sw_deact | input | 1 | Software command to go straight to the shutdown step |
| deact_req | output | 1 | Deactivation request to the shelf manager |
| pwr_btn_n | output | 1 | Active-low power-button pulse to the chipset |
| payload_en | output | 1 | Payload power enable |
| locked | output | 1 | Sticky lock bit, set at power-off |
| mstate | output | 3 | Encoded hot-swap state (1, 4, 5 or 6) |

## Verification
On every cycle, the assertions check the following invariants:
- the legal state codes;
- that the request is raised only in state 5;
- that the pulse appears only in the shutdown states;
- the grant and deny moves out of state 5, including deny priority;
- the software entry;
- that locked is sticky, state 1 is terminal, and locked pairs with payload-off.

Only the bench's scenarios can show the exact pulse width and timeout length, the three-edge latency of the sleep path, and that the latch and sleep inputs pass through synchronizers. They also show that a single sleep input does not end the wait and that a held latch does not retrigger.

// File: rtl/hs_pkg.sv
package hs_pkg;

  typedef enum logic [2:0] {
    ST_ACTIVE    = 3'd0,
    ST_REQ       = 3'd1,
    ST_SHUT_WAIT = 3'd2,
    ST_PWR_OFF   = 3'd3,
    ST_INACTIVE  = 3'd4
  } hs_state_e;

  // External code of each internal state (R11)
  function automatic logic [2:0] mcode(hs_state_e s);
    case (s)
      ST_ACTIVE:    return 3'd4;
      ST_REQ:       return 3'd5;
      ST_SHUT_WAIT: return 3'd6;
      ST_PWR_OFF:   return 3'd6;
      ST_INACTIVE:  return 3'd1;
      default:      return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/hs_rst_sync.sv
module hs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= 2'b00;
    else        stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_int_n = stg_q[1];
endmodule

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int              WIDTH   = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic meta_q;
    logic stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[i];
        stab_q <= RST_VAL[i];
      end else begin
        meta_q <= d[i];
        stab_q <= meta_q;
      end
    end
    assign q[i] = stab_q;
  end
endmodule

// File: rtl/hs_cdown.sv
module hs_cdown #(
  parameter longint unsigned CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int          W    = (CYCLES > 64'd1) ? $clog2(CYCLES) : 1;
  localparam logic [W-1:0] LOAD = W'(CYCLES - 64'd1);
  localparam logic [W-1:0] ONE  = W'(1);

  logic [W-1:0] cnt_q;
  logic         busy_q;
  logic         dec_en;
  logic         stop_en;

  always_comb begin
    dec_en  = busy_q && !start && (cnt_q != '0);
    stop_en = busy_q && !start && (cnt_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      if (start)       cnt_q <= LOAD;
      else if (dec_en) cnt_q <= cnt_q - ONE;
      if (start)        busy_q <= 1'b1;
      else if (stop_en) busy_q <= 1'b0;
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/hs_deact_seq.sv
module hs_deact_seq
  import hs_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 50_000_000,
  parameter int unsigned PULSE_MS   = 20,
  parameter int unsigned TIMEOUT_MS = 180_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       latch_btn_n,
  input  logic       shm_grant,
  input  logic       shm_deny,
  input  logic       acpi_os_present,
  input  logic       sleep_s3_n,
  input  logic       sleep_s5_n,
  input  logic       sw_deact,
  output logic       deact_req,
  output logic       pwr_btn_n,
  output logic       payload_en,
  output logic       locked,
  output logic [2:0] mstate
);
  localparam longint unsigned PULSE_CYC = (longint'(CLK_HZ) * longint'(PULSE_MS)) / 64'd1000;
  localparam longint unsigned TMO_CYC   = (longint'(CLK_HZ) * longint'(TIMEOUT_MS)) / 64'd1000;
  // The timer's busy drop is seen one edge late, so load one cycle less.
  localparam longint unsigned TMO_LOAD  = TMO_CYC - 64'd1;

  logic       rst_int_n;
  logic [2:0] sync_q;
  logic       latch_s, s3_s, s5_s;
  logic       latch_prev_q;
  logic       latch_fall;
  hs_state_e  st_q, st_d, m6_entry;
  logic       start_wait, off_en;
  logic       pulse_busy, tmo_busy;
  logic       req_q, payload_q, locked_q;

  hs_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_int_n (rst_int_n)
  );

  hs_sync #(.WIDTH(3), .RST_VAL(3'b111)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     ({latch_btn_n, sleep_s3_n, sleep_s5_n}),
    .q     (sync_q)
  );

  assign latch_s = sync_q[2];
  assign s3_s    = sync_q[1];
  assign s5_s    = sync_q[0];

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) latch_prev_q <= 1'b1;
    else            latch_prev_q <= latch_s;
  end

  assign latch_fall = latch_prev_q && !latch_s;

  // Next state
  always_comb begin
    m6_entry = acpi_os_present ? ST_SHUT_WAIT : ST_PWR_OFF;
    st_d     = st_q;
    case (st_q)
      ST_ACTIVE: begin
        if (sw_deact)        st_d = m6_entry;
        else if (latch_fall) st_d = ST_REQ;
      end
      ST_REQ: begin
        if (sw_deact)       st_d = m6_entry;
        else if (shm_deny)  st_d = ST_ACTIVE;
        else if (shm_grant) st_d = m6_entry;
      end
      ST_SHUT_WAIT: begin
        if ((!s3_s && !s5_s) || !tmo_busy) st_d = ST_PWR_OFF;
      end
      ST_PWR_OFF:  st_d = ST_INACTIVE;
      ST_INACTIVE: st_d = ST_INACTIVE;
      default:     st_d = ST_ACTIVE;
    endcase
  end

  always_comb begin
    start_wait = (st_d == ST_SHUT_WAIT) && (st_q != ST_SHUT_WAIT);
    off_en     = (st_d == ST_PWR_OFF)   && (st_q != ST_PWR_OFF);
  end

  // State and output registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      st_q      <= ST_ACTIVE;
      req_q     <= 1'b0;
      payload_q <= 1'b1;
      locked_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      req_q <= (st_d == ST_REQ);
      if (off_en) begin
        payload_q <= 1'b0;
        locked_q  <= 1'b1;
      end
    end
  end

  hs_cdown #(.CYCLES(PULSE_CYC)) u_pulse (
    .clk   (clk),
    .rst_n (rst_int_n),
    .start (start_wait),
    .busy  (pulse_busy)
  );

  hs_cdown #(.CYCLES(TMO_LOAD)) u_tmo (
    .clk   (clk),
    .rst_n (rst_int_n),
    .start (start_wait),
    .busy  (tmo_busy)
  );

  assign deact_req  = req_q;
  assign pwr_btn_n  = !pulse_busy;
  assign payload_en = payload_q;
  assign locked     = locked_q;
  assign mstate     = mcode(st_q);
endmodule

// File: rtl/hs_deact_chk.sv
module hs_deact_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       shm_grant,
  input logic       shm_deny,
  input logic       sw_deact,
  input logic       deact_req,
  input logic       pwr_btn_n,
  input logic       payload_en,
  input logic       locked,
  input logic [2:0] mstate
);
  p_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mstate == 3'd1 || mstate == 3'd4 || mstate == 3'd5 || mstate == 3'd6))
    else $error("state code illegal");

  p_req_m5_r2: assert property (@(posedge clk) disable iff (!rst_n)
    deact_req |-> (mstate == 3'd5))
    else $error("request outside state 5");

  p_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mstate == 3'd5 && shm_grant && !shm_deny && !sw_deact) |=> (mstate == 3'd6))
    else $error("grant did not advance");

  p_deny_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mstate == 3'd5 && shm_deny && !sw_deact) |=> (mstate == 3'd4 && !deact_req))
    else $error("deny did not return");

  p_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_btn_n |-> (mstate == 3'd6 || mstate == 3'd1))
    else $error("pulse outside shutdown");

  p_sw_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_deact && (mstate == 3'd4 || mstate == 3'd5)) |=> (mstate == 3'd6 && !deact_req))
    else $error("software entry missed");

  p_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mstate == 3'd1) |-> (locked && !payload_en))
    else $error("inactive without power-off");

  p_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mstate == 3'd1 && $past(mstate) != 3'd1) |-> ($past(locked) && $past(mstate) == 3'd6))
    else $error("inactive entered before lock");

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked)
    else $error("lock cleared");

  p_terminal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mstate == 3'd1) |=> (mstate == 3'd1))
    else $error("left inactive state");
endmodule

bind hs_deact_seq hs_deact_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_int_n),
  .shm_grant  (shm_grant),
  .shm_deny   (shm_deny),
  .sw_deact   (sw_deact),
  .deact_req  (deact_req),
  .pwr_btn_n  (pwr_btn_n),
  .payload_en (payload_en),
  .locked     (locked),
  .mstate     (mstate)
);

// File: tb/test_hs_deact_seq.sv
`timescale 1ns/1ps
module test_hs_deact_seq;
  localparam int unsigned CLK_HZ     = 1000;
  localparam int unsigned PULSE_MS   = 20;
  localparam int unsigned TIMEOUT_MS = 200;
  localparam int PULSE_CYC = 20;   // PULSE_MS * CLK_HZ / 1000
  localparam int TMO_CYC   = 200;  // TIMEOUT_MS * CLK_HZ / 1000

  // Output vector layout: {mstate[2:0], deact_req, pwr_btn_n, payload_en, locked}
  localparam logic [6:0] V_ACTIVE = {3'd4, 1'b0, 1'b1, 1'b1, 1'b0};
  localparam logic [6:0] V_REQ    = {3'd5, 1'b1, 1'b1, 1'b1, 1'b0};
  localparam logic [6:0] V_PULSE  = {3'd6, 1'b0, 1'b0, 1'b1, 1'b0};
  localparam logic [6:0] V_WAIT   = {3'd6, 1'b0, 1'b1, 1'b1, 1'b0};
  localparam logic [6:0] V_OFF    = {3'd6, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam logic [6:0] V_DONE   = {3'd1, 1'b0, 1'b1, 1'b0, 1'b1};

  logic clk, rst_n;
  logic latch_btn_n, shm_grant, shm_deny, acpi_os_present;
  logic sleep_s3_n, sleep_s5_n, sw_deact;
  logic deact_req, pwr_btn_n, payload_en, locked;
  logic [2:0] mstate;

  hs_deact_seq #(.CLK_HZ(CLK_HZ), .PULSE_MS(PULSE_MS), .TIMEOUT_MS(TIMEOUT_MS)) i_hs_deact_seq (
    .clk(clk), .rst_n(rst_n), .latch_btn_n(latch_btn_n), .shm_grant(shm_grant),
    .shm_deny(shm_deny), .acpi_os_present(acpi_os_present), .sleep_s3_n(sleep_s3_n),
    .sleep_s5_n(sleep_s5_n), .sw_deact(sw_deact), .deact_req(deact_req),
    .pwr_btn_n(pwr_btn_n), .payload_en(payload_en), .locked(locked), .mstate(mstate)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int         checks = 0;
  int         errors = 0;
  int         cyc = 0;
  int         last_cyc = 0;
  logic [6:0] last_vec;
  logic [6:0] q_vec[$];
  int         q_gap[$];
  string      q_tag[$];

  function automatic logic [6:0] outvec();
    return {mstate, deact_req, pwr_btn_n, payload_en, locked};
  endfunction

  task automatic expect_ev(input logic [6:0] v, input int gap, input string tag);
    q_vec.push_back(v);
    q_gap.push_back(gap);
    q_tag.push_back(tag);
  endtask

  task automatic check_vec(input logic [6:0] exp, input string tag);
    checks++;
    if (outvec() !== exp) begin
      errors++;
      $display("FAIL %s outputs actual=%b expected=%b", tag, outvec(), exp);
    end
  endtask

  // Monitor: each change of the outputs pops one expected item
  always @(negedge clk) begin
    logic [6:0] cur;
    cyc++;
    cur = outvec();
    if (!rst_n) begin
      last_vec = cur;
      last_cyc = cyc;
    end else if (cur !== last_vec) begin
      checks++;
      if (q_vec.size() == 0) begin
        errors++;
        $display("FAIL unexpected change actual=%b expected=%b (no event due)", cur, last_vec);
      end else begin
        logic [6:0] ev;
        int         eg;
        string      et;
        ev = q_vec.pop_front();
        eg = q_gap.pop_front();
        et = q_tag.pop_front();
        if (cur !== ev) begin
          errors++;
          $display("FAIL %s event actual=%b expected=%b", et, cur, ev);
        end else if (eg >= 0 && (cyc - last_cyc) != eg) begin
          errors++;
          $display("FAIL %s gap actual=%0d expected=%0d", et, cyc - last_cyc, eg);
        end
      end
      last_vec = cur;
      last_cyc = cyc;
    end
  end

  task automatic drain(input string tag);
    for (int i = 0; i < 400 && q_vec.size() != 0; i++) @(negedge clk);
    checks++;
    if (q_vec.size() != 0) begin
      errors++;
      $display("FAIL %s pending=%0d actual_vec=%b expected=%b", tag, q_vec.size(), outvec(), q_vec[0]);
      q_vec.delete(); q_gap.delete(); q_tag.delete();
    end
  endtask

  task automatic idle_inputs();
    latch_btn_n = 1'b1; shm_grant = 1'b0; shm_deny = 1'b0;
    sleep_s3_n = 1'b1;  sleep_s5_n = 1'b1; sw_deact = 1'b0;
  endtask

  task automatic do_reset(input logic acpi);
    @(negedge clk);
    rst_n = 1'b0;
    idle_inputs();
    acpi_os_present = acpi;
    repeat (3) @(negedge clk);
    check_vec(V_ACTIVE, "R1 in reset");
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check_vec(V_ACTIVE, "R1 after reset");
  endtask

  task automatic pulse_in(input int which);
    @(negedge clk);
    case (which)
      0: shm_grant = 1'b1;
      1: shm_deny  = 1'b1;
      2: begin shm_grant = 1'b1; shm_deny = 1'b1; end
      default: sw_deact = 1'b1;
    endcase
    @(negedge clk);
    shm_grant = 1'b0; shm_deny = 1'b0; sw_deact = 1'b0;
  endtask

  task automatic press_latch(input string tag);
    expect_ev(V_REQ, -1, tag);
    @(negedge clk);
    latch_btn_n = 1'b0;
    drain(tag);
  endtask

  // Watchdog
  initial begin
    repeat (20000) @(negedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, actual cycles=%0d expected<20000", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    idle_inputs();
    acpi_os_present = 1'b1;
    last_vec = '0;

    // Scenario A: request, deny, held latch, deny priority, ACPI timeout path
    do_reset(1'b1);
    press_latch("R2 latch starts request");
    expect_ev(V_ACTIVE, -1, "R3 deny returns");
    pulse_in(1);
    drain("R3 deny");
    repeat (10) @(negedge clk);
    check_vec(V_ACTIVE, "R2 held latch no retrigger");
    latch_btn_n = 1'b1;
    repeat (4) @(negedge clk);
    press_latch("R11 code 5 on second request");
    expect_ev(V_ACTIVE, -1, "R3 deny beats grant");
    pulse_in(2);
    drain("R3 deny priority");
    latch_btn_n = 1'b1;
    repeat (4) @(negedge clk);
    press_latch("R2 third request");
    expect_ev(V_PULSE, -1, "R4 pulse starts with state 6");
    expect_ev(V_WAIT, PULSE_CYC, "R4 pulse width");
    expect_ev(V_OFF, TMO_CYC - PULSE_CYC, "R7 timeout with S3 only");
    expect_ev(V_DONE, 1, "R8 inactive one edge after power-off");
    pulse_in(0);
    repeat (5) @(negedge clk);
    sleep_s3_n = 1'b0;
    drain("R7 timeout path");
    // Terminal state: poke every input
    sw_deact = 1'b1; latch_btn_n = 1'b1; shm_grant = 1'b1; sleep_s5_n = 1'b0;
    repeat (6) @(negedge clk);
    latch_btn_n = 1'b0; shm_deny = 1'b1;
    repeat (6) @(negedge clk);
    check_vec(V_DONE, "R10 inputs ignored in state 1");
    idle_inputs();

    // Scenario B: no ACPI OS, grant cuts power at once
    do_reset(1'b0);
    press_latch("R2 request without ACPI");
    expect_ev(V_OFF, -1, "R5 immediate power-off");
    expect_ev(V_DONE, 1, "R8 inactive after immediate power-off");
    pulse_in(0);
    drain("R5 no-ACPI path");
    repeat (5) @(negedge clk);
    check_vec(V_DONE, "R5 no pulse and state 1");

    // Scenario C: software entry from state 4, both sleep signals
    do_reset(1'b1);
    expect_ev(V_PULSE, -1, "R9 software entry from state 4");
    expect_ev(V_WAIT, PULSE_CYC, "R4 pulse width on software entry");
    expect_ev(V_OFF, 13, "R6 sleep signals end wait");
    expect_ev(V_DONE, 1, "R8 inactive after sleep path");
    pulse_in(3);
    wait (pwr_btn_n === 1'b1);
    @(negedge clk);
    repeat (10) @(negedge clk);
    sleep_s3_n = 1'b0; sleep_s5_n = 1'b0;
    drain("R6 sleep path");

    // Scenario D: software entry from state 5 without ACPI
    do_reset(1'b0);
    press_latch("R2 request before software entry");
    expect_ev(V_OFF, -1, "R9 software entry from state 5 drops request");
    expect_ev(V_DONE, 1, "R8 inactive after software entry");
    pulse_in(3);
    drain("R9 software from state 5");
    repeat (4) @(negedge clk);
    check_vec(V_DONE, "R11 code 1 when inactive");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule